// File: doc/BRIEF.md
# Multichannel DDR Sample Serializer

This block turns one parallel sample per channel into a serial word on its own data lane, with all lanes running in lockstep. Each word is sent least significant bit first, one bit per edge of a shared serial clock. Alongside the lanes it drives that serial clock and a frame strobe whose rising edge marks bit 0 of every word. A format select chooses between two's-complement and offset-binary coding. A test select replaces every lane with a fixed word so that a receiver can check its alignment.

The block runs on a single clock `clk` at twelve times the sample rate, so one clock cycle is one bit slot. Both edges of the emitted serial clock therefore fall on `clk` edges, and the serial clock runs at six times the sample rate. The block samples the parallel inputs and both mode selects once per frame, on the edge that ends the last bit slot. The result goes into per-lane shift registers. Changes on the inputs between those edges do not touch the word in flight. A source that feeds the block keeps its sample clock aligned to `frame_o`.

Top module: `ddr_sample_serializer`

## Requirements
- R1: While `rst_n` is low, `lanes_o`, `frame_o` and `sclk_o` are all 0; on the first rising clock edge after reset is released the first word starts.
- R2: Each lane sends WIDTH (12) bits per frame, bit 0 first through bit 11 last, one bit per clock cycle, with frames following back to back without gaps.
- R3: `frame_o` is 1 during bit slots 0 to WIDTH/2-1 (0..5) and 0 during slots WIDTH/2 to WIDTH-1 (6..11); its rising edge coincides with bit 0.
- R4: `sclk_o` changes level in every bit slot; it is 1 during even slots (0, 2, ..., 10) and 0 during odd slots, so every data change lines up with a serial-clock edge.
- R5: With `fmt_offset_i` = 0 and `test_en_i` = 0, the word sent equals the channel sample unchanged (two's complement).
- R6: With `fmt_offset_i` = 1 and `test_en_i` = 0, the word sent is the sample with bit 11 inverted (offset binary), e.g. 0x000 is sent as 0x800 and 0x7FF as 0xFFF.
- R7: With `test_en_i` = 1, every lane sends 0x0BD (binary 0000 1011 1101, bit 11 to bit 0) regardless of sample values and of `fmt_offset_i`.
- R8: Lane k carries channel k, taken from `samples_i[k*12 +: 12]`, and all lanes send their bit n in the same slot.
- R9: Samples and both mode selects are captured only on the clock edge that ends slot 11 (at the first edge after reset); any change during a frame affects only the following word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-slot clock, 12x the sample rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_offset_i | input | 1 | 0 = two's complement, 1 = offset binary |
| test_en_i | input | 1 | 1 = send the fixed test word on every lane |
| samples_i | input | 96 | Eight 12-bit samples, channel k at bits k*12+11..k*12 |
| lanes_o | output | 8 | Serial data, one bit per lane |
| sclk_o | output | 1 | Serial clock, 6x the sample rate, toggles each bit slot |
| frame_o | output | 1 | Frame strobe, high for the first half of each word |

## Verification
The hardest condition to reach is an input change that lands inside a frame that is already being sent. In that case the word in flight must stay intact and the new value must appear exactly one frame later. The stimulus reaches this by syncing to the rising edge of the frame strobe, letting six bit slots pass, and then changing the samples and the format select together. The bench then reads back the rest of that word and the whole of the next one. Mode selects are also flipped mid-frame, to show that a mode only applies from the next frame boundary.

// File: rtl/ddr_sample_serializer.sv
module ddr_sample_serializer #(
  parameter int LANES     = 8,
  parameter int WIDTH     = 12,
  parameter logic [WIDTH-1:0] TEST_WORD = 12'h0BD
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fmt_offset_i,
  input  logic                   test_en_i,
  input  logic [LANES*WIDTH-1:0] samples_i,
  output logic [LANES-1:0]       lanes_o,
  output logic                   sclk_o,
  output logic                   frame_o
);

  localparam int CW   = $clog2(WIDTH);
  localparam int HALF = WIDTH / 2;
  localparam logic [CW-1:0] LAST     = CW'(WIDTH - 1);
  localparam logic [CW-1:0] HALF_END = CW'(HALF - 1);
  localparam logic [WIDTH-1:0] MSB_MASK = WIDTH'(1) << (WIDTH - 1);

  logic [CW-1:0] slot_q;
  logic          run_q;
  logic          load;

  assign load = (slot_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= LAST;
      run_q   <= 1'b0;
      sclk_o  <= 1'b0;
      frame_o <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (load) begin
        slot_q  <= '0;
        sclk_o  <= 1'b1;
        frame_o <= 1'b1;
      end else begin
        slot_q <= slot_q + 1'b1;
        sclk_o <= ~sclk_o;
        if (slot_q == HALF_END) frame_o <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [WIDTH-1:0] sh_q;
    logic [WIDTH-1:0] word;

    assign word = test_en_i    ? TEST_WORD :
                  fmt_offset_i ? (samples_i[k*WIDTH +: WIDTH] ^ MSB_MASK) :
                                  samples_i[k*WIDTH +: WIDTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sh_q <= '0;
      else if (load) sh_q <= word;
      else           sh_q <= sh_q >> 1;
    end

    assign lanes_o[k] = sh_q[0];
  end

  // R1: outputs idle until the first word is loaded
  a_r1_idle_until_load: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (lanes_o == '0 && !frame_o && !sclk_o));

  // R3: frame strobe rises only at the start of a word
  a_r3_frame_rise_at_d0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_o) |-> (slot_q == '0 && $past(slot_q) == LAST));

  // R3: frame strobe falls at the half-word point
  a_r3_frame_fall_half: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_o) |-> (slot_q == CW'(HALF)));

  // R4: serial clock changes in every slot once running
  a_r4_sclk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> (sclk_o != $past(sclk_o)));

  // R7: test word bit 0 on every lane at word start
  a_r7_test_word_d0: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_o) && $past(test_en_i)) |-> (lanes_o == {LANES{TEST_WORD[0]}}));

  // R5, R8: lane 0 bit 0 follows channel 0 sample when not in test mode
  a_r5_lane0_d0: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_o) && !$past(test_en_i)) |-> (lanes_o[0] == $past(samples_i[0])));

endmodule

// File: tb/ddr_sample_serializer_tb.sv
module ddr_sample_serializer_tb_top;
  localparam int LANES = 8;
  localparam int WIDTH = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fmt_offset_i = 1'b0;
  logic test_en_i = 1'b0;
  logic [LANES*WIDTH-1:0] samples_i = '0;
  logic [LANES-1:0] lanes_o;
  logic sclk_o, frame_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [WIDTH-1:0] got [LANES];

  always #2 clk = ~clk;

  ddr_sample_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_offset_i(fmt_offset_i), .test_en_i(test_en_i),
    .samples_i(samples_i), .lanes_o(lanes_o), .sclk_o(sclk_o), .frame_o(frame_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [LANES*WIDTH-1:0] pattern(input logic [WIDTH-1:0] base);
    logic [LANES*WIDTH-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*WIDTH +: WIDTH] = base + WIDTH'(k * 12'h123);
    return v;
  endfunction

  function automatic logic [WIDTH-1:0] expect_word(input logic [LANES*WIDTH-1:0] s, input int k,
                                                   input logic fmt, input logic tst);
    if (tst) return 12'h0BD;
    if (fmt) return s[k*WIDTH +: WIDTH] ^ 12'h800;
    return s[k*WIDTH +: WIDTH];
  endfunction

  task automatic wait_d0();
    logic prev;
    prev = frame_o;
    forever begin
      @(negedge clk);
      if (frame_o && !prev) break;
      prev = frame_o;
    end
  endtask

  // Collect one word per lane; optionally drive new inputs after slot 5.
  task automatic grab(input bit change, input logic [LANES*WIDTH-1:0] ns,
                      input logic nfmt, input logic ntst);
    logic [WIDTH-1:0] fr, sc;
    wait_d0();
    for (int i = 0; i < WIDTH; i++) begin
      if (i > 0) @(negedge clk);
      for (int k = 0; k < LANES; k++) got[k][i] = lanes_o[k];
      fr[i] = frame_o;
      sc[i] = sclk_o;
      if (change && i == 5) begin
        samples_i = ns; fmt_offset_i = nfmt; test_en_i = ntst;
      end
    end
    check("R3 frame pattern", {20'h0, fr}, 32'h03F);
    check("R4 sclk pattern", {20'h0, sc}, 32'h555);
  endtask

  task automatic cmp(input string req, input logic [LANES*WIDTH-1:0] s,
                     input logic fmt, input logic tst);
    for (int k = 0; k < LANES; k++)
      check(req, {20'h0, got[k]}, {20'h0, expect_word(s, k, fmt, tst)});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 lanes in reset", {24'h0, lanes_o}, 32'h0);
    check("R1 frame in reset", {31'h0, frame_o}, 32'h0);
    check("R1 sclk in reset", {31'h0, sclk_o}, 32'h0);
    samples_i = pattern(12'h5A3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first word starts", {30'h0, frame_o, sclk_o}, 32'h3);
    for (int k = 0; k < LANES; k++) got[k][0] = lanes_o[k];
    for (int i = 1; i < WIDTH; i++) begin
      @(negedge clk);
      for (int k = 0; k < LANES; k++) got[k][i] = lanes_o[k];
    end
    cmp("R1 R2 first word", pattern(12'h5A3), 1'b0, 1'b0);
  endtask

  task automatic t_twos();
    logic [LANES*WIDTH-1:0] s;
    s = pattern(12'h7FF);
    @(negedge clk); samples_i = s; fmt_offset_i = 0; test_en_i = 0;
    grab(0, '0, 0, 0);
    cmp("R5 R8 twos complement", s, 0, 0);
    grab(0, '0, 0, 0);
    cmp("R2 back to back", s, 0, 0);
  endtask

  task automatic t_offset();
    logic [LANES*WIDTH-1:0] s;
    s = '0;
    s[WIDTH +: WIDTH] = 12'h7FF;
    s[2*WIDTH +: WIDTH] = 12'h800;
    s[3*WIDTH +: WIDTH] = 12'hFFF;
    s[4*WIDTH +: WIDTH] = 12'h001;
    @(negedge clk); samples_i = s; fmt_offset_i = 1; test_en_i = 0;
    grab(0, '0, 0, 0);
    cmp("R6 offset binary", s, 1, 0);
    check("R6 midscale 0x000->0x800", {20'h0, got[0]}, 32'h800);
  endtask

  task automatic t_test();
    logic [LANES*WIDTH-1:0] s;
    s = pattern(12'hC3C);
    @(negedge clk); samples_i = s; fmt_offset_i = 1; test_en_i = 1;
    grab(0, '0, 0, 0);
    cmp("R7 test word offset", s, 1, 1);
    @(negedge clk); fmt_offset_i = 0;
    grab(0, '0, 0, 0);
    cmp("R7 test word twos", s, 0, 1);
  endtask

  task automatic t_midframe();
    logic [LANES*WIDTH-1:0] a, b;
    a = pattern(12'h1E5);
    b = pattern(12'hA0F);
    @(negedge clk); samples_i = a; fmt_offset_i = 0; test_en_i = 0;
    grab(0, '0, 0, 0);
    grab(1, b, 1, 0);
    cmp("R9 word held through change", a, 0, 0);
    grab(0, '0, 0, 0);
    cmp("R9 change applies next word", b, 1, 0);
    grab(1, a, 1, 1);
    cmp("R9 test enable mid-frame held", b, 1, 0);
    grab(0, '0, 0, 0);
    cmp("R9 R7 test from next word", a, 1, 1);
  endtask

  initial begin
    t_reset();
    t_twos();
    t_offset();
    t_test();
    t_midframe();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule